// File: doc/BRIEF.md
# Dual-Port Interprocessor Mailbox

Two processors, a host and a DSP, exchange short messages through a small set of mailboxes. Each mailbox belongs to one sending side and holds two 16-bit words. The sender may load the first word freely. When it stores the second word, a pending flag is raised and a level interrupt is driven toward the other processor. The receiver can read both words but cannot write them. Its read of the second word acknowledges the message: the flag drops and the interrupt is removed.

Each processor has its own simple register port, made up of a select, a write enable, a word address, write data and registered read data. Both ports see the same word map. Mailboxes 0 to N_H2D-1 carry messages from the host to the DSP. The mailboxes after them carry messages from the DSP to the host. Every mailbox runs its own two-state machine. It has the states IDLE and PENDING. It has the transitions POST (IDLE to PENDING, when the sender writes the second word), ACK (PENDING to IDLE, when the receiver reads the second word without a POST in the same cycle) and REPOST (PENDING stays PENDING, when a POST coincides with an ACK).

Top module: `mbx_dual_port`

## Requirements
- R1: After reset, every mailbox word is 0x0000, every flag and interrupt is low, and both read-data outputs are 0x0000.
- R2: Mailbox m has its first word at word address 2m and its second word at 2m+1. With the defaults, mailbox 0 runs host to DSP and mailboxes 1 and 2 run DSP to host. A sender write to the first word stores the data and leaves the flag and the interrupt unchanged.
- R3: A sender write to the second word stores the data and sets the flag. The mailbox interrupt is high from the next cycle on.
- R4: A receiver read of the second word returns the stored data and clears the flag, so the interrupt is low from the next cycle on.
- R5: A sender read of its own second word leaves the flag set.
- R6: A write from the receiver side, or a write by either port to the status word or to an unmapped address, changes no data and no flag.
- R7: When the sender writes the second word in the same cycle that the receiver reads it, the flag stays set. The read returns the word's earlier value.
- R8: Each interrupt is a level equal to its mailbox flag. The host-to-DSP flags drive irq_to_dsp and the DSP-to-host flags drive irq_to_host. The status word at address 2*N_MB (6 by default) holds flag m in bit m, and both ports can read it.
- R9: Read data appears on the cycle after the read address is presented, and it holds until the next read. A read of any address above the status word returns 0x0000.
- R10: A port can write only the mailboxes it owns. The host writes mailboxes 0 to N_H2D-1 and the DSP writes the rest, so a post raises only the interrupt toward the other side.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| host_cs | input | 1 | Host port access strobe |
| host_we | input | 1 | Host port write (1) or read (0) |
| host_addr | input | ADDR_W | Host port word address |
| host_wdata | input | DATA_W | Host port write data |
| host_rdata | output | DATA_W | Host port read data, registered |
| dsp_cs | input | 1 | DSP port access strobe |
| dsp_we | input | 1 | DSP port write (1) or read (0) |
| dsp_addr | input | ADDR_W | DSP port word address |
| dsp_wdata | input | DATA_W | DSP port write data |
| dsp_rdata | output | DATA_W | DSP port read data, registered |
| irq_to_dsp | output | N_H2D | Level interrupts for host-to-DSP mailboxes |
| irq_to_host | output | N_D2H | Level interrupts for DSP-to-host mailboxes |

## Verification
The REPOST transition is the hardest case to reach from the ports. It needs the sender's write of a second word and the receiver's read of that same word to land in exactly one cycle, with the two ports acting independently. A directed step forces this collision, checks that the flag survives and that the read returns the earlier word, and then acknowledges the message. The random phase draws addresses from a narrow range that includes the second words, the status word and a few unmapped addresses. This makes coincident post and acknowledge events, as well as attempted writes from the receiver side, happen often. A bench model of the mailboxes predicts every read and interrupt.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

    // Per-mailbox handshake state
    typedef enum logic {
        MB_IDLE    = 1'b0,
        MB_PENDING = 1'b1
    } mb_state_e;

endpackage

// File: rtl/mbx_addr_decode.sv
// Word-address decoder shared by both ports: one hit line per register.
module mbx_addr_decode #(
    parameter int N_MB   = 3,
    parameter int ADDR_W = 4
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [N_MB-1:0]   sel_a,
    output logic [N_MB-1:0]   sel_b,
    output logic              sel_stat
);
    localparam int STAT_ADDR = 2 * N_MB;

    for (genvar m = 0; m < N_MB; m++) begin : g_hit
        assign sel_a[m] = (addr == ADDR_W'(2 * m));
        assign sel_b[m] = (addr == ADDR_W'(2 * m + 1));
    end

    assign sel_stat = (addr == ADDR_W'(STAT_ADDR));
endmodule

// File: rtl/mbx_slot.sv
// One mailbox: two data words and the IDLE/PENDING handshake machine.
module mbx_slot
    import mbx_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_a,
    input  logic              wr_b,
    input  logic [DATA_W-1:0] wdata,
    input  logic              ack,
    output logic [DATA_W-1:0] word_a,
    output logic [DATA_W-1:0] word_b,
    output logic              pending
);
    mb_state_e state_q, state_d;

    // Next-state logic: POST, ACK, REPOST
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            MB_IDLE: begin
                if (wr_b) state_d = MB_PENDING;          // POST
            end
            MB_PENDING: begin
                if (ack && !wr_b) state_d = MB_IDLE;     // ACK
                // ack && wr_b: REPOST, stay pending
            end
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= MB_IDLE;
        else        state_q <= state_d;
    end

    // Outputs
    always_comb begin
        pending = (state_q == MB_PENDING);
    end

    // Data words, written by the owning sender only
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word_a <= '0;
            word_b <= '0;
        end else begin
            if (wr_a) word_a <= wdata;
            if (wr_b) word_b <= wdata;
        end
    end
endmodule

// File: rtl/mbx_read_port.sv
// Registered read multiplexer for one port.
module mbx_read_port #(
    parameter int DATA_W = 16,
    parameter int N_MB   = 3
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        rd_en,
    input  logic [N_MB-1:0]             sel_a,
    input  logic [N_MB-1:0]             sel_b,
    input  logic                        sel_stat,
    input  logic [N_MB-1:0][DATA_W-1:0] words_a,
    input  logic [N_MB-1:0][DATA_W-1:0] words_b,
    input  logic [N_MB-1:0]             flags,
    output logic [DATA_W-1:0]           rdata
);
    logic [DATA_W-1:0] stat_word;
    logic [DATA_W-1:0] rd_val;

    assign stat_word = {{(DATA_W - N_MB){1'b0}}, flags};

    // Hit lines are mutually exclusive; an address with no hit yields zero
    always_comb begin
        rd_val = sel_stat ? stat_word : '0;
        for (int m = 0; m < N_MB; m++) begin
            if (sel_a[m]) rd_val = rd_val | words_a[m];
            if (sel_b[m]) rd_val = rd_val | words_b[m];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     rdata <= '0;
        else if (rd_en) rdata <= rd_val;
    end
endmodule

// File: rtl/mbx_dual_port.sv
// Dual-port interprocessor mailbox block.
module mbx_dual_port #(
    parameter int DATA_W = 16,
    parameter int N_H2D  = 1,
    parameter int N_D2H  = 2,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_cs,
    input  logic              host_we,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    output logic [DATA_W-1:0] host_rdata,
    input  logic              dsp_cs,
    input  logic              dsp_we,
    input  logic [ADDR_W-1:0] dsp_addr,
    input  logic [DATA_W-1:0] dsp_wdata,
    output logic [DATA_W-1:0] dsp_rdata,
    output logic [N_H2D-1:0]  irq_to_dsp,
    output logic [N_D2H-1:0]  irq_to_host
);
    localparam int N_MB = N_H2D + N_D2H;

    logic [N_MB-1:0] h_sel_a, h_sel_b, d_sel_a, d_sel_b;
    logic            h_sel_stat, d_sel_stat;

    logic [N_MB-1:0]             slot_wr_a, slot_wr_b, slot_ack, slot_pend;
    logic [N_MB-1:0][DATA_W-1:0] slot_wdata, slot_word_a, slot_word_b;

    logic host_wr, host_rd, dsp_wr, dsp_rd;
    assign host_wr = host_cs &  host_we;
    assign host_rd = host_cs & ~host_we;
    assign dsp_wr  = dsp_cs  &  dsp_we;
    assign dsp_rd  = dsp_cs  & ~dsp_we;

    mbx_addr_decode #(.N_MB(N_MB), .ADDR_W(ADDR_W)) i_host_dec (
        .addr(host_addr), .sel_a(h_sel_a), .sel_b(h_sel_b), .sel_stat(h_sel_stat)
    );

    mbx_addr_decode #(.N_MB(N_MB), .ADDR_W(ADDR_W)) i_dsp_dec (
        .addr(dsp_addr), .sel_a(d_sel_a), .sel_b(d_sel_b), .sel_stat(d_sel_stat)
    );

    // Ownership: the sender port writes, the other port acknowledges
    for (genvar m = 0; m < N_MB; m++) begin : g_slot
        if (m < N_H2D) begin : g_h2d
            assign slot_wr_a[m]  = host_wr & h_sel_a[m];
            assign slot_wr_b[m]  = host_wr & h_sel_b[m];
            assign slot_wdata[m] = host_wdata;
            assign slot_ack[m]   = dsp_rd & d_sel_b[m];
        end else begin : g_d2h
            assign slot_wr_a[m]  = dsp_wr & d_sel_a[m];
            assign slot_wr_b[m]  = dsp_wr & d_sel_b[m];
            assign slot_wdata[m] = dsp_wdata;
            assign slot_ack[m]   = host_rd & h_sel_b[m];
        end

        mbx_slot #(.DATA_W(DATA_W)) i_slot (
            .clk    (clk),
            .rst_n  (rst_n),
            .wr_a   (slot_wr_a[m]),
            .wr_b   (slot_wr_b[m]),
            .wdata  (slot_wdata[m]),
            .ack    (slot_ack[m]),
            .word_a (slot_word_a[m]),
            .word_b (slot_word_b[m]),
            .pending(slot_pend[m])
        );
    end

    mbx_read_port #(.DATA_W(DATA_W), .N_MB(N_MB)) i_host_rd (
        .clk(clk), .rst_n(rst_n), .rd_en(host_rd),
        .sel_a(h_sel_a), .sel_b(h_sel_b), .sel_stat(h_sel_stat),
        .words_a(slot_word_a), .words_b(slot_word_b), .flags(slot_pend),
        .rdata(host_rdata)
    );

    mbx_read_port #(.DATA_W(DATA_W), .N_MB(N_MB)) i_dsp_rd (
        .clk(clk), .rst_n(rst_n), .rd_en(dsp_rd),
        .sel_a(d_sel_a), .sel_b(d_sel_b), .sel_stat(d_sel_stat),
        .words_a(slot_word_a), .words_b(slot_word_b), .flags(slot_pend),
        .rdata(dsp_rdata)
    );

    assign irq_to_dsp  = slot_pend[N_H2D-1:0];
    assign irq_to_host = slot_pend[N_MB-1:N_H2D];
endmodule

// File: rtl/mbx_dual_port_chk.sv
// Port-level properties of the mailbox block.
module mbx_dual_port_chk #(
    parameter int DATA_W = 16,
    parameter int N_H2D  = 1,
    parameter int N_D2H  = 2,
    parameter int ADDR_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              host_cs,
    input logic              host_we,
    input logic [ADDR_W-1:0] host_addr,
    input logic [DATA_W-1:0] host_rdata,
    input logic              dsp_cs,
    input logic              dsp_we,
    input logic [ADDR_W-1:0] dsp_addr,
    input logic [DATA_W-1:0] dsp_rdata,
    input logic [N_H2D-1:0]  irq_to_dsp,
    input logic [N_D2H-1:0]  irq_to_host
);
    localparam int N_MB      = N_H2D + N_D2H;
    localparam int STAT_ADDR = 2 * N_MB;

    logic [N_MB-1:0] irq_all, post, ack, rcv_wr_b, snd_wr_a, snd_rd_b;
    assign irq_all = {irq_to_host, irq_to_dsp};

    for (genvar m = 0; m < N_MB; m++) begin : g_mb
        if (m < N_H2D) begin : g_h2d
            assign post[m]     = host_cs &  host_we & (host_addr == ADDR_W'(2*m+1));
            assign snd_wr_a[m] = host_cs &  host_we & (host_addr == ADDR_W'(2*m));
            assign snd_rd_b[m] = host_cs & ~host_we & (host_addr == ADDR_W'(2*m+1));
            assign ack[m]      = dsp_cs  & ~dsp_we  & (dsp_addr  == ADDR_W'(2*m+1));
            assign rcv_wr_b[m] = dsp_cs  &  dsp_we  & (dsp_addr  == ADDR_W'(2*m+1));
        end else begin : g_d2h
            assign post[m]     = dsp_cs  &  dsp_we  & (dsp_addr  == ADDR_W'(2*m+1));
            assign snd_wr_a[m] = dsp_cs  &  dsp_we  & (dsp_addr  == ADDR_W'(2*m));
            assign snd_rd_b[m] = dsp_cs  & ~dsp_we  & (dsp_addr  == ADDR_W'(2*m+1));
            assign ack[m]      = host_cs & ~host_we & (host_addr == ADDR_W'(2*m+1));
            assign rcv_wr_b[m] = host_cs &  host_we & (host_addr == ADDR_W'(2*m+1));
        end

        a_r3_post_raises: assert property (@(posedge clk) disable iff (!rst_n)
            post[m] |=> irq_all[m]);

        a_r4_ack_drops: assert property (@(posedge clk) disable iff (!rst_n)
            (ack[m] && !post[m]) |=> !irq_all[m]);

        a_r7_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
            (ack[m] && post[m]) |=> irq_all[m]);

        a_r5_sender_read_keeps: assert property (@(posedge clk) disable iff (!rst_n)
            (irq_all[m] && snd_rd_b[m] && !ack[m]) |=> irq_all[m]);

        a_r6_recv_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
            (!irq_all[m] && rcv_wr_b[m] && !post[m]) |=> !irq_all[m]);

        a_r2_first_word_quiet: assert property (@(posedge clk) disable iff (!rst_n)
            (!irq_all[m] && snd_wr_a[m]) |=> !irq_all[m]);
    end

    a_r9_host_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (host_cs && !host_we && (host_addr > ADDR_W'(STAT_ADDR))) |=> (host_rdata == '0));

    a_r9_dsp_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (dsp_cs && !dsp_we && (dsp_addr > ADDR_W'(STAT_ADDR))) |=> (dsp_rdata == '0));
endmodule

bind mbx_dual_port mbx_dual_port_chk #(
    .DATA_W(DATA_W), .N_H2D(N_H2D), .N_D2H(N_D2H), .ADDR_W(ADDR_W)
) i_mbx_dual_port_chk (
    .clk(clk), .rst_n(rst_n),
    .host_cs(host_cs), .host_we(host_we), .host_addr(host_addr), .host_rdata(host_rdata),
    .dsp_cs(dsp_cs), .dsp_we(dsp_we), .dsp_addr(dsp_addr), .dsp_rdata(dsp_rdata),
    .irq_to_dsp(irq_to_dsp), .irq_to_host(irq_to_host)
);

// File: tb/test_mbx_dual_port.sv
`timescale 1ns/1ps
module test_mbx_dual_port;
    localparam int DW = 16, NH = 1, ND = 2, AW = 4;
    localparam int NMB = NH + ND;
    localparam int STAT = 2 * NMB;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          host_cs = 0, host_we = 0, dsp_cs = 0, dsp_we = 0;
    logic [AW-1:0] host_addr = '0, dsp_addr = '0;
    logic [DW-1:0] host_wdata = '0, dsp_wdata = '0;
    logic [DW-1:0] host_rdata, dsp_rdata;
    logic [NH-1:0] irq_to_dsp;
    logic [ND-1:0] irq_to_host;

    always #4 clk = ~clk;   // 125 MHz

    mbx_dual_port #(.DATA_W(DW), .N_H2D(NH), .N_D2H(ND), .ADDR_W(AW)) i_mbx_dual_port (
        .clk(clk), .rst_n(rst_n),
        .host_cs(host_cs), .host_we(host_we), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata),
        .dsp_cs(dsp_cs), .dsp_we(dsp_we), .dsp_addr(dsp_addr),
        .dsp_wdata(dsp_wdata), .dsp_rdata(dsp_rdata),
        .irq_to_dsp(irq_to_dsp), .irq_to_host(irq_to_host)
    );

    // Bench model
    logic [DW-1:0]  mem [0:STAT-1];
    logic [NMB-1:0] flg;
    logic [DW-1:0]  exp_h, exp_d;
    int n_tests = 0, n_fail = 0;
    bit done = 0;

    function automatic logic [DW-1:0] model_read(input logic [AW-1:0] a);
        if (int'(a) < STAT)       return mem[int'(a)];
        else if (int'(a) == STAT) return {{(DW-NMB){1'b0}}, flg};
        else                      return '0;
    endfunction

    task automatic chk(input string tag, input string what, input logic [DW-1:0] act,
                       input logic [DW-1:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic check_all(input string tag);
        chk(tag, "host_rdata", host_rdata, exp_h);
        chk(tag, "dsp_rdata", dsp_rdata, exp_d);
        chk(tag, "irq_to_dsp", DW'(irq_to_dsp), DW'(flg[NH-1:0]));
        chk(tag, "irq_to_host", DW'(irq_to_host), DW'(flg[NMB-1:NH]));
    endtask

    // Called at a falling edge: drive, advance model, check at the next falling edge
    task automatic step(input string tag,
                        input logic hc, input logic hw, input logic [AW-1:0] ha, input logic [DW-1:0] hd,
                        input logic dc, input logic dw, input logic [AW-1:0] da, input logic [DW-1:0] dd);
        logic [NMB-1:0] setv, clrv;
        int hm, dm;
        host_cs = hc; host_we = hw; host_addr = ha; host_wdata = hd;
        dsp_cs = dc;  dsp_we = dw;  dsp_addr = da;  dsp_wdata = dd;
        hm = int'(ha) / 2;
        dm = int'(da) / 2;
        setv = '0; clrv = '0;
        if (hc && !hw) exp_h = model_read(ha);
        if (dc && !dw) exp_d = model_read(da);
        if (hc && hw && int'(ha) < STAT && hm < NH) begin
            mem[int'(ha)] = hd;
            if (ha[0]) setv[hm] = 1'b1;
        end
        if (dc && dw && int'(da) < STAT && dm >= NH) begin
            mem[int'(da)] = dd;
            if (da[0]) setv[dm] = 1'b1;
        end
        if (dc && !dw && int'(da) < STAT && da[0] && dm < NH)  clrv[dm] = 1'b1;
        if (hc && !hw && int'(ha) < STAT && ha[0] && hm >= NH) clrv[hm] = 1'b1;
        flg = (flg & ~clrv) | setv;
        @(negedge clk);
        check_all(tag);
    endtask

    initial begin
        #1600000;
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'h0000_5EED));
        for (int i = 0; i < STAT; i++) mem[i] = '0;
        flg = '0; exp_h = '0; exp_d = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_all("R1");

        // R2: first word only stores
        step("R2", 1,1,4'd0,16'hA5A5, 0,0,4'd0,16'h0);
        step("R2", 0,0,4'd0,16'h0,    1,0,4'd0,16'h0);
        // R3: post host->dsp
        step("R3", 1,1,4'd1,16'h1234, 0,0,4'd0,16'h0);
        // R5: sender read keeps flag
        step("R5", 1,0,4'd1,16'h0,    0,0,4'd0,16'h0);
        // R6: receiver write to B and to status ignored
        step("R6", 0,0,4'd0,16'h0,    1,1,4'd1,16'hDEAD);
        step("R6", 0,0,4'd0,16'h0,    1,1,4'd6,16'hFFFF);
        step("R6", 0,0,4'd0,16'h0,    1,0,4'd1,16'h0);   // also R4 ack
        // R7: post and ack in one cycle
        step("R3", 1,1,4'd1,16'h0F0F, 0,0,4'd0,16'h0);
        step("R7", 1,1,4'd1,16'h7777, 1,0,4'd1,16'h0);
        step("R4", 0,0,4'd0,16'h0,    1,0,4'd1,16'h0);
        // R10: DSP posts mailbox 2, host tries to write DSP-owned words
        step("R10", 0,0,4'd0,16'h0,   1,1,4'd5,16'hBEEF);
        step("R10", 1,1,4'd3,16'h5555, 1,1,4'd2,16'h2222);
        // R8: status on both ports
        step("R8", 1,0,4'd6,16'h0,    1,0,4'd6,16'h0);
        step("R4", 1,0,4'd5,16'h0,    0,0,4'd0,16'h0);
        // R9: unmapped reads zero, data held without reads
        step("R9", 1,0,4'd9,16'h0,    1,0,4'd15,16'h0);
        step("R9", 0,0,4'd0,16'h0,    0,0,4'd0,16'h0);

        // Random phase
        for (int i = 0; i < 3000; i++) begin
            logic hc, hw, dc, dw;
            logic [AW-1:0] ha, da;
            hc = ($urandom_range(0, 3) != 0);
            dc = ($urandom_range(0, 3) != 0);
            hw = $urandom_range(0, 1) == 1;
            dw = $urandom_range(0, 1) == 1;
            ha = AW'($urandom_range(0, 8));
            da = AW'($urandom_range(0, 8));
            step("R8", hc, hw, ha, DW'($urandom), dc, dw, da, DW'($urandom));
        end

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule